// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Overrun Lockout

This block is the receive side of a clock-synchronous serial port that also has a chip select. It can run as bus master. In that mode it generates the serial clock from the system clock and samples the data line. It can also run as a slave. In that mode it follows an external clock, but only while an active-low select line is held low. Frames are `BITS` bits long and arrive most significant bit first. Each finished frame is copied into a receive data register and raises a data-full flag. A frame that finishes while the flag is still set raises an overrun flag instead, and the block then refuses any further reception until software clears it.

The CPU reaches the block through a small register port with three locations: control, status and data. In master mode the receiver never clocks on its own. Each read of the data register clears data-full. If reception is enabled and the stop-after-one-byte bit is clear, the same read also launches exactly one burst of `BITS` clock periods. The first such read is therefore a dummy read. A clock-phase bit selects which serial clock edge samples the data, and so it also selects the point in the frame at which the flags rise.

Top module: `srx_top`

## Requirements
- R1: After reset the control, status and data registers read 0, `sclk_out` is 1 and both interrupt outputs are 0.
- R2: In master mode (control bit 4 = 1), with receive enable (control bit 0) = 1, stop bit (control bit 1) = 0 and no overrun, a read of the data register (address 2) starts a burst of exactly `BITS` serial clock periods. The clock idles high, each half period lasts `DIV/2` system clocks, and `sclk_out` returns high and stays high after the burst.
- R3: The received bits are assembled most significant bit first. When the last bit is sampled, the byte is loaded into the data register and data-full (status bit 0) becomes 1.
- R4: A read of the data register clears data-full.
- R5: In master mode, a data-register read does not start a burst when the stop bit is 1 or when receive enable is 0.
- R6: With phase (control bit 3) = 1, bits are sampled on the falling (odd) edges, and data-full is already set right after the `BITS`-th falling edge. With phase = 0, bits are sampled on the rising (even) edges, and data-full is still 0 after the `BITS`-th falling edge and becomes 1 at the following rising edge.
- R7: `irq_rx` equals interrupt enable (control bit 2) AND data-full. `irq_ovr` equals interrupt enable AND overrun.
- R8: A frame that completes while data-full is 1 sets overrun (status bit 1) and leaves the data register holding the older byte.
- R9: While overrun is 1, slave frames are ignored and master reads start no burst.
- R10: Writing status with bit 1 = 0 clears overrun. Writing it with bit 1 = 1 leaves overrun set. Once overrun is cleared, reception works again.
- R11: In slave mode (control bit 4 = 0), bits are taken from `sclk_in` edges only while `cs_n_in` is low. Edges while `cs_n_in` is high are ignored, and raising `cs_n_in` discards a partial frame.
- R12: In slave mode with receive enable = 0, whole frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (one cycle per read) |
| cpu_wdata | input | BITS | Write data |
| cpu_rdata | output | BITS | Read data for the selected register |
| sclk_in | input | 1 | External serial clock used in slave mode |
| cs_n_in | input | 1 | Active-low chip select used in slave mode |
| sdi | input | 1 | Serial data input |
| sclk_out | output | 1 | Serial clock generated in master mode, idle high |
| sclk_oe | output | 1 | High when the block drives the serial clock (master mode) |
| irq_rx | output | 1 | Receive interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |

## Verification
The overrun lockout is the hardest state to reach. In master mode it can never arise, because the read that launches a burst also clears data-full. The stimulus therefore switches to slave mode and sends two complete frames without a read in between. It then checks a third frame, a data read and a master-mode read while the lock is active, and only then clears the flag. Phase-dependent flag timing is checked in the middle of a master burst: the bench waits for the final falling clock edge and inspects `irq_rx` before the last rising edge.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef struct packed {
        logic master;   // bit 4
        logic phase;    // bit 3
        logic irq_en;   // bit 2
        logic stop1;    // bit 1
        logic rx_en;    // bit 0
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/srx_mclk.sv
module srx_mclk #(
    parameter int BITS = 8,
    parameter int DIV  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic phase,
    output logic sclk,
    output logic busy,
    output logic smp_stb
);
    localparam int HALF  = DIV / 2;
    localparam int DCW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int EDGES = 2 * BITS;
    localparam int EW    = $clog2(EDGES);

    typedef struct packed {
        logic           busy;
        logic           sclk;
        logic [DCW-1:0] div;
        logic [EW-1:0]  edges;
    } st_t;

    st_t  q, d;
    logic tick;

    always_comb begin
        d    = q;
        tick = q.busy && (q.div == DCW'(HALF - 1));
        // even count -> next edge is odd (falling)
        smp_stb = tick && (q.edges[0] ? !phase : phase);
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.div   = '0;
                d.edges = '0;
                d.sclk  = 1'b1;
            end
        end else if (tick) begin
            d.div   = '0;
            d.sclk  = !q.sclk;
            d.edges = q.edges + 1'b1;
            if (q.edges == EW'(EDGES - 1)) d.busy = 1'b0;
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sclk: 1'b1, div: '0, edges: '0};
        else        q <= d;
    end

    assign sclk = q.sclk;
    assign busy = q.busy;

    AST_BURST_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> q.sclk); // R2
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> q.sclk && q.edges == '0); // R2

endmodule

// File: rtl/srx_slave_front.sv
module srx_slave_front (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic sdi_in,
    input  logic phase,
    output logic sel,
    output logic smp_stb,
    output logic smp_bit
);
    typedef struct packed {
        logic [1:0] sck;
        logic [1:0] csn;
        logic [1:0] dat;
        logic       sck_prev;
    } st_t;

    st_t  q, d;
    logic rise, fall;

    always_comb begin
        d          = q;
        d.sck      = {q.sck[0], sclk_in};
        d.csn      = {q.csn[0], cs_n_in};
        d.dat      = {q.dat[0], sdi_in};
        d.sck_prev = q.sck[1];
        rise       = q.sck[1] && !q.sck_prev;
        fall       = !q.sck[1] && q.sck_prev;
        sel        = !q.csn[1];
        smp_stb    = sel && (phase ? fall : rise);
        smp_bit    = q.dat[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sck: 2'b11, csn: 2'b11, dat: 2'b00, sck_prev: 1'b1};
        else        q <= d;
    end

endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            stb,
    input  logic            bit_in,
    output logic            done,
    output logic [BITS-1:0] byte_out
);
    localparam int CW = $clog2(BITS);

    typedef struct packed {
        logic [BITS-2:0] sh;
        logic [CW-1:0]   cnt;
    } st_t;

    st_t q, d;

    always_comb begin
        d        = q;
        done     = stb && !clr && (q.cnt == CW'(BITS - 1));
        byte_out = {q.sh, bit_in};
        if (clr) begin
            d.cnt = '0;
        end else if (stb) begin
            d.sh  = {q.sh[BITS-3:0], bit_in};
            d.cnt = done ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_CLR_RESTARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q.cnt == '0); // R11

endmodule

// File: rtl/srx_top.sv
module srx_top
    import srx_pkg::*;
#(
    parameter int BITS = 8,
    parameter int DIV  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cpu_addr,
    input  logic            cpu_wr,
    input  logic            cpu_rd,
    input  logic [BITS-1:0] cpu_wdata,
    output logic [BITS-1:0] cpu_rdata,
    input  logic            sclk_in,
    input  logic            cs_n_in,
    input  logic            sdi,
    output logic            sclk_out,
    output logic            sclk_oe,
    output logic            irq_rx,
    output logic            irq_ovr
);
    typedef struct packed {
        ctrl_t           ctrl;
        logic            full;
        logic            ovr;
        logic [BITS-1:0] data;
    } reg_t;

    reg_t q, d;

    logic            rd_data, start;
    logic            m_busy, m_stb, m_sclk;
    logic            s_sel, s_stb, s_bit;
    logic            sh_clr, sh_stb, sh_bit, sh_done;
    logic [BITS-1:0] sh_byte;
    logic            unused_wbits;

    assign unused_wbits = ^cpu_wdata[BITS-1:5];

    srx_mclk #(.BITS(BITS), .DIV(DIV)) i_mclk (
        .clk(clk), .rst_n(rst_n), .start(start), .phase(q.ctrl.phase),
        .sclk(m_sclk), .busy(m_busy), .smp_stb(m_stb)
    );

    srx_slave_front i_slave (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n_in(cs_n_in),
        .sdi_in(sdi), .phase(q.ctrl.phase),
        .sel(s_sel), .smp_stb(s_stb), .smp_bit(s_bit)
    );

    srx_shift #(.BITS(BITS)) i_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .stb(sh_stb), .bit_in(sh_bit),
        .done(sh_done), .byte_out(sh_byte)
    );

    always_comb begin
        rd_data = cpu_rd && (cpu_addr == ADDR_DATA);
        start   = rd_data && q.ctrl.master && q.ctrl.rx_en && !q.ctrl.stop1
                  && !q.ovr && !m_busy;
        if (q.ctrl.master) begin
            sh_clr = start;
            sh_stb = m_stb;
            sh_bit = sdi;
        end else begin
            sh_clr = !s_sel;
            sh_stb = s_stb && q.ctrl.rx_en && !q.ovr;
            sh_bit = s_bit;
        end
    end

    always_comb begin
        d = q;
        if (cpu_wr && cpu_addr == ADDR_CTRL) d.ctrl = ctrl_t'(cpu_wdata[4:0]);
        if (cpu_wr && cpu_addr == ADDR_STAT && !cpu_wdata[1]) d.ovr = 1'b0;
        if (rd_data) d.full = 1'b0;
        if (sh_done) begin
            if (q.full) begin
                d.ovr = 1'b1;
            end else begin
                d.data = sh_byte;
                d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (cpu_addr)
            ADDR_CTRL: cpu_rdata = BITS'(q.ctrl);
            ADDR_STAT: cpu_rdata = BITS'({q.ovr, q.full});
            ADDR_DATA: cpu_rdata = q.data;
            default:   cpu_rdata = '0;
        endcase
    end

    assign sclk_out = m_sclk;
    assign sclk_oe  = q.ctrl.master;
    assign irq_rx   = q.ctrl.irq_en && q.full;
    assign irq_ovr  = q.ctrl.irq_en && q.ovr;

    AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !sh_done |=> !q.full); // R4
    AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done && !rd_data |=> q.full); // R3
    AST_OVR_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |=> $stable(q.data)); // R8
    AST_NO_BURST_IN_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |=> !$rose(m_busy)); // R9

endmodule

// File: tb/test_srx_top.sv
module test_srx_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  BITS = 8;
    localparam int  DIV  = 4;
    localparam int  HALF = DIV / 2;
    localparam int  SH   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cpu_addr = '0;
    logic            cpu_wr = 1'b0;
    logic            cpu_rd = 1'b0;
    logic [BITS-1:0] cpu_wdata = '0;
    logic [BITS-1:0] cpu_rdata;
    logic            sclk_in = 1'b1;
    logic            cs_n_in = 1'b1;
    logic            sdi = 1'b0;
    logic            sclk_out, sclk_oe, irq_rx, irq_ovr;

    int  n_checks = 0;
    int  n_errors = 0;
    int  edge_cnt = 0;
    time t_first = 0;
    time t_last  = 0;

    srx_top #(.BITS(BITS), .DIV(DIV)) i_srx_top (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .sclk_in(sclk_in), .cs_n_in(cs_n_in), .sdi(sdi),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
    );

    always #(CLK_PERIOD / 2) clk = !clk;

    always @(sclk_out) begin
        edge_cnt = edge_cnt + 1;
        if (edge_cnt == 1) t_first = $time;
        t_last = $time;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int k);
        case (k)
            16: return 8'h00;
            17: return 8'hFF;
            18: return 8'h80;
            19: return 8'h01;
            default: return 8'(k * 37 + 5);
        endcase
    endfunction

    // acts as the remote slave: next bit goes out on the non-sampling edge
    task automatic master_drive(input logic [7:0] b, input logic p);
        for (int i = 6; i >= 0; i--) begin
            if (p) @(negedge sclk_out); else @(posedge sclk_out);
            if (p) @(posedge sclk_out); else @(negedge sclk_out);
            sdi = b[i];
        end
        if (p) @(negedge sclk_out);
        @(negedge clk);
        chk(irq_rx == p, "R6 flag after last falling edge", irq_rx, p);
        if (!p) begin
            @(posedge sclk_out);
            @(negedge clk);
        end
        chk(irq_rx == 1'b1, "R3 full set at frame end", irq_rx, 1);
    endtask

    task automatic master_byte(input logic [7:0] b, input logic p);
        logic [7:0] v;
        cpu_write(2'd0, {3'b000, 1'b1, p, 1'b1, 1'b0, 1'b1});
        sdi = b[7];
        edge_cnt = 0;
        fork
            cpu_read(2'd2, v);
            master_drive(b, p);
        join
        repeat (2 * HALF + 2) @(negedge clk);
        chk(edge_cnt == 2 * BITS, "R2 edge count", edge_cnt, 2 * BITS);
        chk((t_last - t_first) == time'((2 * BITS - 1) * HALF * CLK_PERIOD),
            "R2 burst length", int'(t_last - t_first), (2 * BITS - 1) * HALF * CLK_PERIOD);
        chk(sclk_out == 1'b1, "R2 clock idles high", sclk_out, 1);
        chk(irq_rx == 1'b1, "R7 irq_rx with full", irq_rx, 1);
        cpu_write(2'd0, {3'b000, 1'b1, p, 1'b1, 1'b1, 1'b1});
        edge_cnt = 0;
        cpu_read(2'd2, v);
        chk(v == b, "R3 received byte", v, b);
        cpu_read(2'd1, v);
        chk(v[0] == 1'b0, "R4 read clears full", v[0], 0);
        chk(irq_rx == 1'b0, "R7 irq_rx drops", irq_rx, 0);
        cpu_read(2'd2, v);
        repeat (4 * DIV) @(negedge clk);
        chk(edge_cnt == 0, "R5 stop bit blocks burst", edge_cnt, 0);
    endtask

    task automatic slave_frame(input logic [7:0] b, input int nbits, input logic csv,
                               input logic p);
        cs_n_in = csv;
        repeat (SH) @(negedge clk);
        for (int i = 7; i > 7 - nbits; i--) begin
            if (p) sdi = b[i];
            repeat (SH) @(negedge clk);
            sclk_in = 1'b0;
            if (!p) sdi = b[i];
            repeat (SH) @(negedge clk);
            sclk_in = 1'b1;
        end
        repeat (SH) @(negedge clk);
        cs_n_in = 1'b1;
        repeat (SH) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sclk_out == 1'b1, "R1 sclk_out", sclk_out, 1);
        chk(irq_rx == 1'b0 && irq_ovr == 1'b0, "R1 irqs", {irq_rx, irq_ovr}, 0);
        cpu_read(2'd0, v); chk(v == 8'h00, "R1 control", v, 0);
        cpu_read(2'd1, v); chk(v == 8'h00, "R1 status", v, 0);
        cpu_read(2'd2, v); chk(v == 8'h00, "R1 data", v, 0);

        // R5: master with receive disabled
        cpu_write(2'd0, 8'h10);
        edge_cnt = 0;
        cpu_read(2'd2, v);
        repeat (4 * DIV) @(negedge clk);
        chk(edge_cnt == 0, "R5 disabled master no burst", edge_cnt, 0);

        // master sweep, both phases
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 20; k++)
                master_byte(pat(k), 1'(p));

        // slave sweep, both phases (R11)
        for (int p = 0; p < 2; p++) begin
            cpu_write(2'd0, {4'b0000, 1'(p), 3'b101});
            for (int k = 0; k < 20; k++) begin
                slave_frame(pat(k), 8, 1'b0, 1'(p));
                chk(irq_rx == 1'b1, "R11 slave full", irq_rx, 1);
                cpu_read(2'd2, v);
                chk(v == pat(k), "R11 slave byte", v, pat(k));
            end
        end

        // R11: select high ignores edges; partial frame discarded
        cpu_write(2'd0, 8'h05);
        slave_frame(8'h6E, 8, 1'b1, 1'b0);
        cpu_read(2'd1, v);
        chk(v[0] == 1'b0, "R11 deselected frame ignored", v[0], 0);
        slave_frame(8'hF0, 4, 1'b0, 1'b0);
        cpu_read(2'd1, v);
        chk(v[0] == 1'b0, "R11 partial frame no full", v[0], 0);
        slave_frame(8'h2D, 8, 1'b0, 1'b0);
        cpu_read(2'd2, v);
        chk(v == 8'h2D, "R11 partial frame discarded", v, 8'h2D);

        // R12: receive disabled
        cpu_write(2'd0, 8'h04);
        slave_frame(8'h77, 8, 1'b0, 1'b0);
        cpu_read(2'd1, v);
        chk(v == 8'h00, "R12 disabled slave ignored", v, 0);

        // R7: interrupt enable off
        cpu_write(2'd0, 8'h01);
        slave_frame(8'h5B, 8, 1'b0, 1'b0);
        chk(irq_rx == 1'b0, "R7 irq masked", irq_rx, 0);
        cpu_read(2'd1, v);
        chk(v[0] == 1'b1, "R7 full while masked", v[0], 1);
        cpu_read(2'd2, v);

        // R8: overrun
        cpu_write(2'd0, 8'h05);
        slave_frame(8'h3C, 8, 1'b0, 1'b0);
        slave_frame(8'hC3, 8, 1'b0, 1'b0);
        chk(irq_ovr == 1'b1, "R7 irq_ovr", irq_ovr, 1);
        cpu_read(2'd1, v);
        chk(v == 8'h03, "R8 status full+ovr", v, 3);
        cpu_read(2'd2, v);
        chk(v == 8'h3C, "R8 older byte kept", v, 8'h3C);

        // R9: locked out
        slave_frame(8'h99, 8, 1'b0, 1'b0);
        cpu_read(2'd1, v);
        chk(v == 8'h02, "R9 slave frame ignored", v, 2);
        cpu_read(2'd2, v);
        chk(v == 8'h3C, "R9 data unchanged", v, 8'h3C);
        cpu_write(2'd0, 8'h15);
        edge_cnt = 0;
        cpu_read(2'd2, v);
        repeat (4 * DIV) @(negedge clk);
        chk(edge_cnt == 0, "R9 master blocked", edge_cnt, 0);
        cpu_write(2'd0, 8'h05);

        // R10: clearing
        cpu_write(2'd1, 8'h02);
        cpu_read(2'd1, v);
        chk(v[1] == 1'b1, "R10 write 1 keeps ovr", v[1], 1);
        cpu_write(2'd1, 8'h00);
        cpu_read(2'd1, v);
        chk(v == 8'h00, "R10 write 0 clears ovr", v, 0);
        chk(irq_ovr == 1'b0, "R10 irq_ovr drops", irq_ovr, 0);
        slave_frame(8'h42, 8, 1'b0, 1'b0);
        cpu_read(2'd2, v);
        chk(v == 8'h42, "R10 reception resumes", v, 8'h42);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule